// File: doc/BRIEF.md
# Forwarding and Load-Use Stall Unit

This block is the data-hazard controller of a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory access, writeback). Operands are read in decode and results are written in writeback, so only read-after-write conflicts exist. The unit compares the source register numbers of the instruction in decode and the instruction in execute with the destination numbers held in the later pipeline registers. From that comparison it drives the select codes of the two ALU operand multiplexers and the select of the branch comparator. It also drives one stall line. That line freezes the program counter and the fetch/decode register, and it injects an empty slot into execute.

Only register numbers and control bits move through the block. Each cycle the fetch side presents an instruction class and a 32-bit word. The block decodes the word into source fields, destination field, write enable and load flag, and carries these through a small pipeline model. The writeback register number and its write enable are brought out so that the register-file write port can be driven and the passage of bubbles can be seen. Conditional branches test their register in decode, so decode is checked against later stages as well as execute.

Top module: `fwd_stall_unit`

## Requirements
- R1: In the first cycle after synchronous reset is released, stall is 0, both ALU select codes are 0, the branch select is 0 and no writeback is signalled.
- R2: Each ALU select code is 2 bits wide: 0 means the register-file value, 1 means the value from the memory/writeback register, and 2 means the value from the execute/memory register. The value 3 never appears. When the instruction directly ahead of an execute-stage consumer writes that consumer's source register, the code for that operand is 2.
- R3: When the writer is two instructions ahead of the consumer, the operand code is 1. When the writer is three instructions ahead, the code is 0, because writeback updates the register file in the first half of the cycle and decode reads it in the second half. Up to four consecutive consumers of one result each get the proper code.
- R4: When both the execute/memory register and the memory/writeback register write the same source register, the code is 2, so the younger result wins.
- R5: A write to register 0 is never forwarded, never causes a stall and never raises the writeback enable.
- R6: A load followed directly by an instruction that reads the loaded register in execute stalls exactly one cycle. The consumer's operand code is then 1.
- R7: During a stall the fetch/decode register keeps its contents, and the slot that enters execute carries no write. That empty slot reaches writeback three cycles later with the write enable low, and the program order of the writes is kept.
- R8: A conditional branch whose tested register is written by the ALU instruction just ahead of it stalls for one cycle. The branch select is then 1, which routes the execute/memory result to the comparator.
- R9: A conditional branch whose tested register is loaded by the instruction two ahead of it stalls for one cycle and uses no branch forwarding.
- R10: A conditional branch whose tested register is loaded by the instruction just ahead of it stalls for two cycles. No stall ever lasts more than two consecutive cycles.
- R11: Instruction class codes are 0 no-op, 1 register-register ALU, 2 register-immediate ALU, 3 load, 4 store, 5 conditional branch, and 6 and 7 act as no-op. The first source is always in bits 25:21. Bits 20:16 hold the second source for register-register ALU operations and stores, and hold the destination for immediate ALU operations and loads. Bits 15:11 hold the destination for register-register ALU operations.
- R12: A field that an instruction class does not read as a source never produces a forwarding code or a stall. Bits 20:16 of immediate ALU operations and loads, and bits 15:11 of classes other than register-register, fall under this rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_kind | input | 3 | Class code of the fetched instruction |
| fetch_word | input | WORD_W | Fetched instruction word |
| stall | output | 1 | Hold the PC and fetch/decode, insert a bubble into execute |
| fwd_a | output | 2 | Select code for the first ALU operand |
| fwd_b | output | 2 | Select code for the second ALU operand |
| fwd_br | output | 1 | Route the execute/memory result to the branch comparator |
| wb_wen | output | 1 | Register-file write enable from writeback |
| wb_rd | output | 5 | Register-file write index from writeback |

## Verification
The bench builds the block with its default 32-bit word and 32 registers. During random runs it draws every register field from registers 0 to 3. With so few registers in use, back-to-back producers of the same register, double matches across both forwarding stages, loads feeding branches at distances one and two, and writes to register 0 all occur often. Directed sequences then pin down the exact stall counts for branches and loads, the priority between the two forwarding stages, and the fields that must be ignored.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int REG_COUNT = 32;
    localparam int IDX_W     = $clog2(REG_COUNT);
    localparam int SRC1_LSB  = 21;
    localparam int SRC2_LSB  = 16;
    localparam int DST_LSB   = 11;

    typedef enum logic [2:0] {
        K_NOP = 3'd0,
        K_RR  = 3'd1,
        K_RI  = 3'd2,
        K_LD  = 3'd3,
        K_ST  = 3'd4,
        K_BR  = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        SEL_RF  = 2'd0,
        SEL_WB  = 2'd1,
        SEL_MEM = 2'd2
    } sel_e;

    typedef struct packed {
        logic [IDX_W-1:0] src1;
        logic [IDX_W-1:0] src2;
        logic [IDX_W-1:0] dst;
        logic             use1;
        logic             use2;
        logic             use_br;
        logic             wen;
        logic             load;
    } ctrl_t;

    localparam ctrl_t BUBBLE = '0;

    function automatic logic same_reg(input logic [IDX_W-1:0] a,
                                      input logic [IDX_W-1:0] b);
        return (a == b) && (a != '0);
    endfunction
endpackage

// File: rtl/hz_decode.sv
module hz_decode
    import hz_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  kind_e             kind,
    input  logic [WORD_W-1:0] word,
    output ctrl_t             ctrl
);
    logic [IDX_W-1:0] f_hi, f_mid, f_lo;

    assign f_hi  = word[SRC1_LSB +: IDX_W];
    assign f_mid = word[SRC2_LSB +: IDX_W];
    assign f_lo  = word[DST_LSB  +: IDX_W];

    always_comb begin
        ctrl = BUBBLE;
        unique case (kind)
            K_RR: begin
                ctrl.src1 = f_hi;  ctrl.use1 = 1'b1;
                ctrl.src2 = f_mid; ctrl.use2 = 1'b1;
                ctrl.dst  = f_lo;  ctrl.wen  = (f_lo != '0);
            end
            K_RI, K_LD: begin
                ctrl.src1 = f_hi;  ctrl.use1 = 1'b1;
                ctrl.dst  = f_mid; ctrl.wen  = (f_mid != '0);
                ctrl.load = (kind == K_LD);
            end
            K_ST: begin
                ctrl.src1 = f_hi;  ctrl.use1 = 1'b1;
                ctrl.src2 = f_mid; ctrl.use2 = 1'b1;
            end
            K_BR: begin
                ctrl.src1   = f_hi;
                ctrl.use_br = 1'b1;
            end
            default: ctrl = BUBBLE;
        endcase
    end
endmodule

// File: rtl/hz_pipe.sv
module hz_pipe
    import hz_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  kind_e             fetch_kind,
    input  logic [WORD_W-1:0] fetch_word,
    input  ctrl_t             id_ctrl,
    output kind_e             id_kind,
    output logic [WORD_W-1:0] id_word,
    output ctrl_t             ex_c,
    output ctrl_t             mem_c,
    output ctrl_t             wb_c
);
    always_ff @(posedge clk) begin
        if (rst) begin
            id_kind <= K_NOP;
            id_word <= '0;
            ex_c    <= BUBBLE;
            mem_c   <= BUBBLE;
            wb_c    <= BUBBLE;
        end else begin
            if (!stall) begin
                id_kind <= fetch_kind;
                id_word <= fetch_word;
                ex_c    <= id_ctrl;
            end else begin
                ex_c    <= BUBBLE;
            end
            mem_c <= ex_c;
            wb_c  <= mem_c;
        end
    end
endmodule

// File: rtl/hz_detect.sv
module hz_detect
    import hz_pkg::*;
(
    input  ctrl_t      id_c,
    input  ctrl_t      ex_c,
    input  ctrl_t      mem_c,
    input  ctrl_t      wb_c,
    output logic       stall,
    output logic [1:0] fwd_a,
    output logic [1:0] fwd_b,
    output logic       fwd_br
);
    localparam int N_OPND = 2;

    logic [N_OPND-1:0][IDX_W-1:0] src;
    logic [N_OPND-1:0]            used;
    logic [N_OPND-1:0][1:0]       sel;

    assign src[0]  = ex_c.src1;
    assign src[1]  = ex_c.src2;
    assign used[0] = ex_c.use1;
    assign used[1] = ex_c.use2;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        logic hit_mem, hit_wb;
        assign hit_mem = used[g] && mem_c.wen && same_reg(mem_c.dst, src[g]);
        assign hit_wb  = used[g] && wb_c.wen  && same_reg(wb_c.dst,  src[g]);
        assign sel[g]  = hit_mem ? SEL_MEM : (hit_wb ? SEL_WB : SEL_RF);
    end

    assign fwd_a = sel[0];
    assign fwd_b = sel[1];

    logic ex_hits_id, br_hits_ex, br_hits_mem;

    assign ex_hits_id = ex_c.wen &&
        ((id_c.use1   && same_reg(ex_c.dst, id_c.src1)) ||
         (id_c.use2   && same_reg(ex_c.dst, id_c.src2)) ||
         (id_c.use_br && same_reg(ex_c.dst, id_c.src1)));
    assign br_hits_ex  = id_c.use_br && ex_c.wen  && same_reg(ex_c.dst,  id_c.src1);
    assign br_hits_mem = id_c.use_br && mem_c.wen && same_reg(mem_c.dst, id_c.src1);

    assign stall  = (ex_c.load && ex_hits_id) ||
                    (!ex_c.load && br_hits_ex) ||
                    (mem_c.load && br_hits_mem);
    assign fwd_br = br_hits_mem && !mem_c.load;
endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
    import hz_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        fetch_kind,
    input  logic [WORD_W-1:0] fetch_word,
    output logic              stall,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              fwd_br,
    output logic              wb_wen,
    output logic [IDX_W-1:0]  wb_rd
);
    kind_e             id_kind;
    logic [WORD_W-1:0] id_word;
    logic [2:0]        id_kind_bits;
    ctrl_t             id_c, ex_c, mem_c, wb_c;
    logic [IDX_W-1:0]  ex_rs1, ex_rs2;

    hz_decode #(.WORD_W(WORD_W)) u_dec (
        .kind (id_kind),
        .word (id_word),
        .ctrl (id_c)
    );

    hz_pipe #(.WORD_W(WORD_W)) u_pipe (
        .clk        (clk),
        .rst        (rst),
        .stall      (stall),
        .fetch_kind (kind_e'(fetch_kind)),
        .fetch_word (fetch_word),
        .id_ctrl    (id_c),
        .id_kind    (id_kind),
        .id_word    (id_word),
        .ex_c       (ex_c),
        .mem_c      (mem_c),
        .wb_c       (wb_c)
    );

    hz_detect u_det (
        .id_c   (id_c),
        .ex_c   (ex_c),
        .mem_c  (mem_c),
        .wb_c   (wb_c),
        .stall  (stall),
        .fwd_a  (fwd_a),
        .fwd_b  (fwd_b),
        .fwd_br (fwd_br)
    );

    assign wb_wen       = wb_c.wen;
    assign wb_rd        = wb_c.dst;
    assign ex_rs1       = ex_c.src1;
    assign ex_rs2       = ex_c.src2;
    assign id_kind_bits = id_kind;
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic [1:0]        fwd_a,
    input logic [1:0]        fwd_b,
    input logic              fwd_br,
    input logic              wb_wen,
    input logic [IDX_W-1:0]  ex_rs1,
    input logic [IDX_W-1:0]  ex_rs2,
    input logic [WORD_W-1:0] id_word,
    input logic [2:0]        id_kind
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!stall && fwd_a == 2'd0 && fwd_b == 2'd0 && !fwd_br && !wb_wen)); // R1

    AST_SEL_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (fwd_a != 2'd3) && (fwd_b != 2'd3)); // R2

    AST_ZERO_SRC_A: assert property (@(posedge clk) disable iff (rst)
        (fwd_a != 2'd0) |-> (ex_rs1 != '0)); // R5

    AST_ZERO_SRC_B: assert property (@(posedge clk) disable iff (rst)
        (fwd_b != 2'd0) |-> (ex_rs2 != '0)); // R5

    AST_STALL_HOLDS_DECODE: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(id_word) && $stable(id_kind))); // R7

    AST_BUBBLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        stall |-> ##3 !wb_wen); // R7

    AST_STALL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (stall && $past(stall)) |=> !stall); // R10
endmodule

bind fwd_stall_unit hz_checker #(.WORD_W(WORD_W), .IDX_W(hz_pkg::IDX_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .stall   (stall),
    .fwd_a   (fwd_a),
    .fwd_b   (fwd_b),
    .fwd_br  (fwd_br),
    .wb_wen  (wb_wen),
    .ex_rs1  (ex_rs1),
    .ex_rs2  (ex_rs2),
    .id_word (id_word),
    .id_kind (id_kind_bits)
);

// File: tb/fwd_stall_unit_test.sv
module fwd_stall_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  fetch_kind = 3'd0;
    logic [31:0] fetch_word = '0;
    logic        stall, fwd_br, wb_wen;
    logic [1:0]  fwd_a, fwd_b;
    logic [4:0]  wb_rd;

    fwd_stall_unit uut (
        .clk(clk), .rst(rst), .fetch_kind(fetch_kind), .fetch_word(fetch_word),
        .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_br(fwd_br),
        .wb_wen(wb_wen), .wb_rd(wb_rd)
    );

    always #5 clk = ~clk;

    typedef struct {
        int s1, s2, d;
        bit u1, u2, ub, wen, ld;
    } bc_t;

    int checks = 0, errors = 0;
    bit done = 0;

    bc_t m_ex, m_mem, m_wb;
    int  m_idk = 0;
    logic [31:0] m_idw = '0;

    int  pk [256];
    logic [31:0] pw [256];
    int  pn = 0, pc = 0;
    int  n_stall, n_f2, n_f1, n_br;

    function automatic bc_t bubble();
        bc_t b;
        b.s1 = 0; b.s2 = 0; b.d = 0;
        b.u1 = 0; b.u2 = 0; b.ub = 0; b.wen = 0; b.ld = 0;
        return b;
    endfunction

    function automatic logic [31:0] mk(int a, int b, int c);
        return (32'(a) << 21) | (32'(b) << 16) | (32'(c) << 11);
    endfunction

    // R11 field positions and class codes
    function automatic bc_t bdec(int k, logic [31:0] w);
        bc_t r = bubble();
        int a = int'(w[25:21]);
        int b = int'(w[20:16]);
        int c = int'(w[15:11]);
        case (k)
            1: begin r.s1 = a; r.s2 = b; r.u1 = 1; r.u2 = 1; r.d = c; r.wen = (c != 0); end
            2, 3: begin r.s1 = a; r.u1 = 1; r.d = b; r.wen = (b != 0); r.ld = (k == 3); end
            4: begin r.s1 = a; r.s2 = b; r.u1 = 1; r.u2 = 1; end
            5: begin r.s1 = a; r.ub = 1; end
            default: ;
        endcase
        return r;
    endfunction

    function automatic bit hit(bit en, int a, int b);
        return en && a == b && a != 0;
    endfunction

    function automatic int sel(bit u, int s);
        if (hit(u && m_mem.wen, m_mem.d, s)) return 2;
        if (hit(u && m_wb.wen, m_wb.d, s)) return 1;
        return 0;
    endfunction

    task automatic check(string req, int got, int exp, string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic step();
        bc_t id;
        bit  es;
        int  ea, eb, ebr;
        @(negedge clk);
        id = bdec(m_idk, m_idw);
        es = (m_ex.wen && m_ex.ld &&
              (hit(id.u1, m_ex.d, id.s1) || hit(id.u2, m_ex.d, id.s2) || hit(id.ub, m_ex.d, id.s1)))
          || (m_ex.wen && !m_ex.ld && hit(id.ub, m_ex.d, id.s1))
          || (m_mem.wen && m_mem.ld && hit(id.ub, m_mem.d, id.s1));
        ea  = sel(m_ex.u1, m_ex.s1);
        eb  = sel(m_ex.u2, m_ex.s2);
        ebr = (m_mem.wen && !m_mem.ld && hit(id.ub, m_mem.d, id.s1)) ? 1 : 0;
        check(id.ub ? "R8" : "R6", int'(stall), int'(es), "stall");
        check(ea == 2 ? "R2" : (ea == 1 ? "R3" : "R12"), int'(fwd_a), ea, "fwd_a");
        check(eb == 2 ? "R4" : (eb == 1 ? "R3" : "R12"), int'(fwd_b), eb, "fwd_b");
        check("R8", int'(fwd_br), ebr, "fwd_br");
        check("R7", int'(wb_wen), int'(m_wb.wen), "wb_wen");
        if (m_wb.wen) check("R7", int'(wb_rd), m_wb.d, "wb_rd");
        n_stall += int'(stall);
        if (fwd_a == 2) n_f2++;
        if (fwd_b == 2) n_f2++;
        if (fwd_a == 1) n_f1++;
        if (fwd_b == 1) n_f1++;
        n_br += int'(fwd_br);
        if (pc < pn) begin
            fetch_kind = 3'(pk[pc]);
            fetch_word = pw[pc];
        end else begin
            fetch_kind = 3'd0;
            fetch_word = '0;
        end
        @(posedge clk);
        m_wb  = m_mem;
        m_mem = m_ex;
        if (es) m_ex = bubble();
        else begin
            m_ex  = id;
            m_idk = int'(fetch_kind);
            m_idw = fetch_word;
            if (pc < pn) pc++;
        end
    endtask

    task automatic push(int k, int a, int b, int c);
        pk[pn] = k;
        pw[pn] = mk(a, b, c);
        pn++;
    endtask

    task automatic run_seq(string req, int e_stall, int e_f2, int e_f1, int e_br);
        n_stall = 0; n_f2 = 0; n_f1 = 0; n_br = 0; pc = 0;
        while (pc < pn) step();
        repeat (6) step();
        check(req, n_stall, e_stall, "stall cycles");
        check(req, n_f2, e_f2, "code-2 selects");
        check(req, n_f1, e_f1, "code-1 selects");
        check(req, n_br, e_br, "branch selects");
        pn = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_ex = bubble(); m_mem = bubble(); m_wb = bubble();
        void'($urandom(32'd4242));
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", int'(stall), 0, "stall after reset");
        check("R1", int'(fwd_a) + int'(fwd_b), 0, "selects after reset");
        check("R1", int'(fwd_br) + int'(wb_wen), 0, "branch/wb after reset");

        // R2 R3: one producer, four consumers
        push(1, 2, 3, 1); push(1, 1, 5, 4); push(1, 7, 1, 6); push(1, 1, 1, 8); push(1, 1, 9, 10);
        run_seq("R3", 0, 1, 1, 0);
        // R4 youngest producer wins
        push(2, 0, 1, 0); push(2, 0, 1, 0); push(1, 1, 0, 2);
        run_seq("R4", 0, 1, 0, 0);
        // R5 register 0 writes
        push(2, 0, 0, 0); push(1, 0, 0, 3); push(3, 2, 0, 0); push(1, 0, 0, 5); push(5, 0, 0, 0);
        run_seq("R5", 0, 0, 0, 0);
        // R6 load-use
        push(3, 2, 1, 0); push(1, 1, 4, 3);
        run_seq("R6", 1, 0, 1, 0);
        // R8 branch after ALU
        push(1, 2, 3, 7); push(5, 7, 0, 0);
        run_seq("R8", 1, 0, 0, 1);
        // R9 branch two after load
        push(3, 2, 7, 0); push(1, 2, 3, 9); push(5, 7, 0, 0);
        run_seq("R9", 1, 0, 0, 0);
        // R10 branch right after load
        push(3, 2, 7, 0); push(5, 7, 0, 0);
        run_seq("R10", 2, 0, 0, 0);
        // R12 unread fields
        push(2, 0, 9, 10); push(1, 10, 0, 11); push(2, 6, 11, 0); push(3, 0, 12, 13); push(1, 13, 0, 14);
        run_seq("R12", 0, 0, 0, 0);

        // random mix, registers 0..3
        for (int i = 0; i < 200; i++)
            push(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
        n_stall = 0; n_f2 = 0; n_f1 = 0; n_br = 0; pc = 0;
        while (pc < pn) step();
        repeat (6) step();
        pn = 0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule